// File: doc/BRIEF.md
# Child Transaction Cancellation Handler

This block sits on the caller side of a child transaction. When the parent transaction is reset or killed, the parent raises `cleanup_start`. The handler then cancels any outstanding child work and leaves the channel in a clean state. It reads a 3-bit child status code and the full indications of two one-entry buffers: the request buffer toward the child server and the response buffer coming back. It drives a kill line to the child server. When a stale response is left over, it pops that response and discards it. It raises `cleanup_done` for one cycle when it returns to idle.

The path the handler takes depends on where the child is. A child that is still queued gets the kill held until the server drains its request, and the handler then waits for a killed status. A running child gets the kill held until the status reads killed or done, because the child may finish in the same cycle. After that the handler drains any response. A child that has already finished without its response being consumed only has that response discarded, and no kill is raised. The handler also keeps the pending flag: `child_launch` sets it, and the flag drops when cleanup completes.

The handler has eight named states:
- IDLE: waits for `cleanup_start`.
- EVAL: classifies the child.
- KILL_QUEUED: kill held while the request is still queued.
- WAIT_KILLED: kill released, waiting for the killed status.
- KILL_RUNNING: kill held while the child runs.
- RELEASE: kill released, the response buffer is inspected.
- DRAIN: one pop is issued.
- FINISH: the done pulse.

The transitions are:
- IDLE to FINISH, on a start with nothing pending.
- IDLE to EVAL, on a start with a child pending.
- EVAL to KILL_QUEUED, when the status is ready and the request buffer is full.
- EVAL to KILL_RUNNING, when the status is in_progress.
- EVAL to DRAIN, when the status is done and the response buffer is full.
- EVAL to FINISH, for any other valid status.
- KILL_QUEUED to WAIT_KILLED, once the request buffer is empty.
- WAIT_KILLED to FINISH, once the status is killed.
- KILL_RUNNING to RELEASE, once the status is killed or done.
- RELEASE to DRAIN, when the response buffer is full.
- RELEASE to FINISH, when the response buffer is empty.
- DRAIN to FINISH.
- FINISH to IDLE.

Top module: `child_cancel_handler`

## Requirements
- R1: While `rst` is high at a clock edge, the handler returns to IDLE. After that edge, `kill`, `rsp_pop`, `cleanup_done` and `child_pending` are all 0.
- R2: A `child_launch` sampled high sets `child_pending` from the next cycle. The flag stays set until a cleanup completes.
- R3: A `cleanup_start` sampled in IDLE with `child_pending` low makes `cleanup_done` high in the next cycle. `kill` and `rsp_pop` stay low throughout.
- R4: In EVAL, status ready (1) with `req_full` high raises `kill` in the next cycle. `kill` stays high until `req_full` is sampled low, and it is low in the following cycle. `cleanup_done` then follows one cycle after status killed (4) is sampled.
- R5: In EVAL, status in_progress (2) raises `kill` in the next cycle. `kill` stays high until status killed (4) or done (3) is sampled, and then drops for one release cycle. If `rsp_full` is high in that release cycle, `rsp_pop` is high for exactly one cycle before `cleanup_done`. Otherwise `cleanup_done` follows the release cycle directly.
- R6: A child that reports done (3) while `kill` is held exits the kill phase exactly as a killed status does.
- R7: In EVAL, status done (3) with `rsp_full` high produces one `rsp_pop` cycle and then `cleanup_done`, with `kill` never raised.
- R8: Status codes 5, 6 and 7 hold the handler in EVAL, KILL_QUEUED, WAIT_KILLED, KILL_RUNNING or RELEASE. All outputs keep their values until a valid code arrives.
- R9: `cleanup_done` is high for exactly one cycle. `child_pending` is already low in that cycle.
- R10: With a child pending, any other valid status in EVAL completes the cleanup in the next cycle without `kill` or `rsp_pop`. The other valid statuses are idle (0), killed (4), done with `rsp_full` low, and ready with `req_full` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| child_launch | input | 1 | Parent issued a child transaction; sets the pending flag |
| cleanup_start | input | 1 | Parent was reset or killed; starts cancellation |
| child_status | input | 3 | Child status: 0 idle, 1 ready, 2 in_progress, 3 done, 4 killed |
| req_full | input | 1 | One-entry request buffer holds a request (empty when low) |
| rsp_full | input | 1 | One-entry response buffer holds a response (empty when low) |
| kill | output | 1 | Kill line to the child server |
| rsp_pop | output | 1 | Pops and discards the response buffer entry |
| cleanup_done | output | 1 | One-cycle pulse when cancellation completes |
| child_pending | output | 1 | A child transaction is outstanding |

## Verification
The bench models the handler behaviourally and compares all outputs on every clock while it steps the child through each window.

The child positions tried, and what each one separates:
- Nothing pending, and pending with an already idle child. These separate the short path from the paths that raise kill.
- A queued request that the server drains several cycles later. This shows that kill tracks the request buffer rather than the status.
- A running child that ends killed with no response, and one that ends done with a response waiting. These separate the drain from the no-drain exit and cover a completion that races the kill.
- A finished child with an unconsumed response. This shows a pop without any kill.
- Invalid status codes injected in EVAL and in KILL_RUNNING. These show that the handler holds its state.

// File: rtl/cch_pkg.sv
`timescale 1ns/1ps
package cch_pkg;

    localparam int unsigned STATUS_W = 3;

    localparam logic [STATUS_W-1:0] CS_IDLE    = 3'd0;
    localparam logic [STATUS_W-1:0] CS_READY   = 3'd1;
    localparam logic [STATUS_W-1:0] CS_RUNNING = 3'd2;
    localparam logic [STATUS_W-1:0] CS_DONE    = 3'd3;
    localparam logic [STATUS_W-1:0] CS_KILLED  = 3'd4;

    typedef enum logic [2:0] {
        H_IDLE,
        H_EVAL,
        H_KILL_QUEUED,
        H_WAIT_KILLED,
        H_KILL_RUNNING,
        H_RELEASE,
        H_DRAIN,
        H_FINISH
    } hstate_e;

endpackage

// File: rtl/cch_pending.sv
`timescale 1ns/1ps
module cch_pending (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clear_i,
    output logic pending_o
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (clear_i) begin
            pend_q <= 1'b0;
        end else if (set_i) begin
            pend_q <= 1'b1;
        end
    end

    assign pending_o = pend_q;
endmodule

// File: rtl/cch_fsm.sv
`timescale 1ns/1ps
module cch_fsm
    import cch_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                pending_i,
    input  logic [STATUS_W-1:0] status_i,
    input  logic                req_full_i,
    input  logic                rsp_full_i,
    output hstate_e             state_o,
    output hstate_e             next_o
);
    hstate_e state_q;
    hstate_e state_d;
    logic    status_ok;

    assign status_ok = (status_i <= CS_KILLED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= H_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H_IDLE: begin
                if (start_i) begin
                    state_d = pending_i ? H_EVAL : H_FINISH;
                end
            end
            H_EVAL: begin
                if (status_ok) begin
                    if (status_i == CS_READY && req_full_i) begin
                        state_d = H_KILL_QUEUED;
                    end else if (status_i == CS_RUNNING) begin
                        state_d = H_KILL_RUNNING;
                    end else if (status_i == CS_DONE && rsp_full_i) begin
                        state_d = H_DRAIN;
                    end else begin
                        state_d = H_FINISH;
                    end
                end
            end
            H_KILL_QUEUED: begin
                if (status_ok && !req_full_i) begin
                    state_d = H_WAIT_KILLED;
                end
            end
            H_WAIT_KILLED: begin
                if (status_i == CS_KILLED) begin
                    state_d = H_FINISH;
                end
            end
            H_KILL_RUNNING: begin
                if (status_i == CS_KILLED || status_i == CS_DONE) begin
                    state_d = H_RELEASE;
                end
            end
            H_RELEASE: begin
                if (status_ok) begin
                    state_d = rsp_full_i ? H_DRAIN : H_FINISH;
                end
            end
            H_DRAIN:  state_d = H_FINISH;
            H_FINISH: state_d = H_IDLE;
            default:  state_d = H_IDLE;
        endcase
    end

    assign state_o = state_q;
    assign next_o  = state_d;
endmodule

// File: rtl/cch_outdec.sv
`timescale 1ns/1ps
module cch_outdec
    import cch_pkg::*;
(
    input  hstate_e state_i,
    output logic    kill_o,
    output logic    pop_o,
    output logic    done_o,
    output logic    busy_o
);
    always_comb begin
        kill_o = 1'b0;
        pop_o  = 1'b0;
        done_o = 1'b0;
        busy_o = 1'b1;
        unique case (state_i)
            H_IDLE:         busy_o = 1'b0;
            H_EVAL:         ;
            H_KILL_QUEUED:  kill_o = 1'b1;
            H_WAIT_KILLED:  ;
            H_KILL_RUNNING: kill_o = 1'b1;
            H_RELEASE:      ;
            H_DRAIN:        pop_o  = 1'b1;
            H_FINISH:       done_o = 1'b1;
            default:        busy_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/child_cancel_handler.sv
`timescale 1ns/1ps
module child_cancel_handler
    import cch_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                child_launch,
    input  logic                cleanup_start,
    input  logic [STATUS_W-1:0] child_status,
    input  logic                req_full,
    input  logic                rsp_full,
    output logic                kill,
    output logic                rsp_pop,
    output logic                cleanup_done,
    output logic                child_pending
);
    hstate_e cur_state;
    hstate_e nxt_state;
    logic    busy;
    logic    clear_pend;

    assign clear_pend = (nxt_state == H_FINISH) && (cur_state != H_FINISH);

    cch_pending u_pend (
        .clk       (clk),
        .rst       (rst),
        .set_i     (child_launch),
        .clear_i   (clear_pend),
        .pending_o (child_pending)
    );

    cch_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (cleanup_start),
        .pending_i  (child_pending),
        .status_i   (child_status),
        .req_full_i (req_full),
        .rsp_full_i (rsp_full),
        .state_o    (cur_state),
        .next_o     (nxt_state)
    );

    cch_outdec u_out (
        .state_i (cur_state),
        .kill_o  (kill),
        .pop_o   (rsp_pop),
        .done_o  (cleanup_done),
        .busy_o  (busy)
    );
endmodule

// File: rtl/cch_checker.sv
`timescale 1ns/1ps
module cch_checker (
    input logic       clk,
    input logic       rst,
    input logic       cleanup_start,
    input logic [2:0] child_status,
    input logic       req_full,
    input logic       rsp_full,
    input logic       kill,
    input logic       rsp_pop,
    input logic       cleanup_done,
    input logic       child_pending,
    input logic       busy
);
    // R1: reset clears the outputs
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!kill && !rsp_pop && !cleanup_done && !child_pending));

    // R3: start with nothing pending finishes in one cycle
    p_fast_finish_r3: assert property (@(posedge clk) disable iff (rst)
        (cleanup_start && !busy && !child_pending) |=> (cleanup_done && !kill && !rsp_pop));

    // R4 and R6: kill is released only after the request drains or the child ends
    p_kill_release_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(kill) |-> ($past(!req_full) || $past(child_status == 3'd3) || $past(child_status == 3'd4)));

    // R5: a pop happens only while a response is present and never alongside kill
    p_pop_guarded_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_pop |-> (rsp_full && !kill));

    // R8: an invalid status keeps kill where it was
    p_invalid_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !cleanup_done && !rsp_pop && child_status > 3'd4) |=> $stable(kill));

    // R9: the done pulse lasts one cycle and the pending flag is already clear
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        cleanup_done |-> (!child_pending ##1 !cleanup_done));
endmodule

bind child_cancel_handler cch_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .cleanup_start (cleanup_start),
    .child_status  (child_status),
    .req_full      (req_full),
    .rsp_full      (rsp_full),
    .kill          (kill),
    .rsp_pop       (rsp_pop),
    .cleanup_done  (cleanup_done),
    .child_pending (child_pending),
    .busy          (busy)
);

// File: tb/child_cancel_handler_test.sv
`timescale 1ns/1ps
module child_cancel_handler_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       child_launch = 1'b0;
    logic       cleanup_start = 1'b0;
    logic [2:0] child_status = 3'd0;
    logic       req_full = 1'b0;
    logic       rsp_full = 1'b0;
    logic       kill;
    logic       rsp_pop;
    logic       cleanup_done;
    logic       child_pending;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // behavioural reference: phase labels are strings of the expected activity
    string m_phase = "idle";
    bit    m_pend  = 1'b0;

    always #2 clk = ~clk;

    child_cancel_handler uut (
        .clk           (clk),
        .rst           (rst),
        .child_launch  (child_launch),
        .cleanup_start (cleanup_start),
        .child_status  (child_status),
        .req_full      (req_full),
        .rsp_full      (rsp_full),
        .kill          (kill),
        .rsp_pop       (rsp_pop),
        .cleanup_done  (cleanup_done),
        .child_pending (child_pending)
    );

    always @(posedge clk) begin
        string nxt;
        bit    bad;
        bad = (child_status > 3'd4);
        nxt = m_phase;
        if (rst) begin
            m_phase = "idle";
            m_pend  = 1'b0;
        end else begin
            if (m_phase == "idle" && cleanup_start) begin
                nxt = m_pend ? "classify" : "end";
            end else if (m_phase == "classify" && !bad) begin
                if (child_status == 3'd1 && req_full)      nxt = "killq";
                else if (child_status == 3'd2)             nxt = "killrun";
                else if (child_status == 3'd3 && rsp_full) nxt = "pop";
                else                                        nxt = "end";
            end else if (m_phase == "killq" && !bad && !req_full) begin
                nxt = "waitk";
            end else if (m_phase == "waitk" && child_status == 3'd4) begin
                nxt = "end";
            end else if (m_phase == "killrun" && (child_status == 3'd3 || child_status == 3'd4)) begin
                nxt = "rel";
            end else if (m_phase == "rel" && !bad) begin
                nxt = rsp_full ? "pop" : "end";
            end else if (m_phase == "pop") begin
                nxt = "end";
            end else if (m_phase == "end") begin
                nxt = "idle";
            end
            if (nxt == "end" && m_phase != "end") m_pend = 1'b0;
            else if (child_launch)                m_pend = 1'b1;
            m_phase = nxt;
        end
    end

    task automatic chk(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", cur_req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        chk("kill", kill, (m_phase == "killq" || m_phase == "killrun"));
        chk("rsp_pop", rsp_pop, (m_phase == "pop"));
        chk("cleanup_done", cleanup_done, (m_phase == "end"));
        chk("child_pending", child_pending, m_pend);
        if (m_phase == "end") begin
            chk("R9 pending low at done", child_pending, 1'b0);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic launch();
        child_launch = 1'b1;
        step(1);
        child_launch = 1'b0;
    endtask

    task automatic start();
        cleanup_start = 1'b1;
        step(1);
        cleanup_start = 1'b0;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);

        // R3: nothing pending
        cur_req = "R3";
        child_status = 3'd2;
        start();
        step(3);

        // R2 and R10: pending, child idle
        cur_req = "R2";
        child_status = 3'd0;
        launch();
        step(2);
        cur_req = "R10";
        start();
        step(3);

        // R4: queued request drained later
        cur_req = "R4";
        child_status = 3'd1;
        req_full = 1'b1;
        launch();
        start();
        step(4);
        req_full = 1'b0;
        step(3);
        child_status = 3'd4;
        step(4);

        // R5: running child ends killed, no response
        cur_req = "R5";
        child_status = 3'd2;
        launch();
        start();
        step(4);
        child_status = 3'd4;
        step(4);

        // R6: running child completes while kill is held, response waiting
        cur_req = "R6";
        child_status = 3'd2;
        launch();
        start();
        step(2);
        child_status = 3'd3;
        rsp_full = 1'b1;
        step(3);
        rsp_full = 1'b0;
        step(3);

        // R7: finished child, unconsumed response
        cur_req = "R7";
        child_status = 3'd3;
        rsp_full = 1'b1;
        launch();
        start();
        step(2);
        rsp_full = 1'b0;
        step(3);

        // R8: invalid status in EVAL, then in KILL_RUNNING
        cur_req = "R8";
        child_status = 3'd7;
        launch();
        start();
        step(4);
        child_status = 3'd2;
        step(2);
        child_status = 3'd6;
        step(4);
        child_status = 3'd4;
        step(4);

        // R1: reset in the middle of a cancellation
        cur_req = "R1";
        child_status = 3'd2;
        launch();
        start();
        step(2);
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule